// File: doc/BRIEF.md
# Audio Control Register Slave on a Two-Wire Bus

This block is the control-register front end of a television stereo audio processor. It is a slave on a two-wire serial bus (I2C), clocked by the system clock. Both bus lines are synchronised and then filtered against glitches. The block keeps four small registers: right volume, left volume and two control words. From these it drives the decoded control outputs that the analog path uses. It also gives each channel a mute flag and a signed gain value in dB.

A host writes a subaddress byte, then one or more data bytes. Consecutive data bytes go to consecutive registers and wrap around after the fourth. A read takes no subaddress. It returns one status byte that reports the stereo pilot detector and a flag marking that a reset has happened since the last read. Reset mutes the main outputs. The lowest address bit comes from a strap input, so two devices can share one bus.

Top module: `audio_ctrl_i2c_slave`

## Requirements
- R1: The device answers to the 7-bit address 1011011 when `addr_strap` is 1 and to 1011010 when it is 0. For any other address the slave leaves SDA released and does not change any register until the next START.
- R2: In a write, the byte after the address is the subaddress. Only its bits 1:0 select the register: 0 is right volume, 1 is left volume, 2 is control word A, 3 is control word B. Bits 7:2 of the subaddress and bit 7 of every data byte are ignored. Every byte addressed to the device is acknowledged.
- R3: Each further data byte in the same write goes to the next register index. The index wraps from 3 back to 0.
- R4: A read returns one byte, most significant bit first. Bit 0 is `pilot_det`, bit 1 is the reset-seen flag and bits 7:2 are 0.
- R5: The reset-seen flag is 1 after reset. It clears once a status byte has been shifted out in full.
- R6: After reset, control word A holds 0x02 (general mute set) and all other registers are 0. SDA is released and the bus receiver is idle.
- R7: Control word A maps its bits as follows:
  - bit 0: `line_stereo`
  - bit 1: `gen_mute`
  - bit 2: `avl_en`
  - bit 3: `avl_fast_decay`
  - bits 5:4: `avl_attack`
  - bit 6: `line_mute`
- R8: Control word B maps its bits as follows:
  - bits 1:0: `tone_sel`
  - bit 2: `src_ext`
  - bit 3: `force_mono`
  - bit 4: `tone_linear`
- R9: `mute_r` and `mute_l` are 1 when that channel's volume code is at or below 0x2F, or when `gen_mute` is 1.
- R10: `gain_r_db` and `gain_l_db` report the gain in dB as a signed value:
  - codes 0x30 to 0x7B give code minus 0x6F, which spans -63 to +12;
  - codes 0x7C to 0x7F give +12;
  - codes 0x00 to 0x2F give -64, meaning mute.
- R11: A pulse on SDA or SCL that lasts fewer than `FILT_LEN` clock cycles is rejected. Such a pulse on SDA while SCL is high does not act as a START or a STOP, and a write in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | Clock line pull-low enable (never asserted) |
| sda_oe | output | 1 | Data line pull-low enable |
| addr_strap | input | 1 | Address bit 0 strap |
| pilot_det | input | 1 | Stereo pilot detected |
| vol_r | output | 7 | Right volume code |
| vol_l | output | 7 | Left volume code |
| gain_r_db | output | 8 | Right gain in dB, signed, -64 = mute |
| gain_l_db | output | 8 | Left gain in dB, signed, -64 = mute |
| mute_r | output | 1 | Right main output muted |
| mute_l | output | 1 | Left main output muted |
| gen_mute | output | 1 | General mute |
| line_stereo | output | 1 | Line output stereo mode |
| avl_en | output | 1 | Automatic level control enable |
| avl_fast_decay | output | 1 | Increased level-control decay current |
| avl_attack | output | 2 | Level-control attack time select |
| line_mute | output | 1 | Line output mute |
| tone_sel | output | 2 | Fixed tone setting select |
| src_ext | output | 1 | External source selected |
| force_mono | output | 1 | Forced mono at main outputs |
| tone_linear | output | 1 | Linear tone enable |

## Verification
The hardest case to reach from the ports is a short glitch on SDA while SCL is high. Without the filter, that glitch would decode as a false START or STOP in the middle of a byte. To reach it, the bench drives a whole data byte in which every bit carries a three-cycle inverted pulse during the high phase of SCL. It then checks that the register received the intended value. Random writes also start from random full 8-bit subaddresses and use lengths of up to six bytes. This exercises the wrap from index 3 to index 0 and the ignored upper bits.

// File: rtl/audio_ctrl_i2c_slave.sv
module audio_ctrl_i2c_slave #(
  parameter int          FILT_LEN   = 4,
  parameter logic [5:0]  ADDR_HI    = 6'b101101,
  parameter logic [6:0]  MUTE_CODE  = 7'h2F,
  parameter logic [6:0]  MAX_CODE   = 7'h7B,
  parameter logic [6:0]  UNITY_CODE = 7'h6F
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              addr_strap,
  input  logic              pilot_det,
  output logic [6:0]        vol_r,
  output logic [6:0]        vol_l,
  output logic signed [7:0] gain_r_db,
  output logic signed [7:0] gain_l_db,
  output logic              mute_r,
  output logic              mute_l,
  output logic              gen_mute,
  output logic              line_stereo,
  output logic              avl_en,
  output logic              avl_fast_decay,
  output logic [1:0]        avl_attack,
  output logic              line_mute,
  output logic [1:0]        tone_sel,
  output logic              src_ext,
  output logic              force_mono,
  output logic              tone_linear
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic signed [7:0] MUTE_DB = -8'sd64;
  localparam logic signed [7:0] MAX_DB  = $signed({1'b0, MAX_CODE}) - $signed({1'b0, UNITY_CODE});

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_SUB, S_SACK, S_WDAT, S_DACK, S_RDAT, S_RACK, S_WAIT
  } state_t;

  // line conditioning: index 1 = SDA, index 0 = SCL
  logic [1:0]    s1, s2, flt, flt_q;
  logic [CW-1:0] fcnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt <= 2'b11; flt_q <= 2'b11;
      fcnt[0] <= '0; fcnt[1] <= '0;
    end else begin
      s1    <= {sda_i, scl_i};
      s2    <= s1;
      flt_q <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i])
          fcnt[i] <= '0;
        else if (fcnt[i] == CW'(FILT_LEN - 1)) begin
          flt[i]  <= s2[i];
          fcnt[i] <= '0;
        end else
          fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  =  flt[0] & ~flt_q[0];
  assign scl_fall  = ~flt[0] &  flt_q[0];
  assign start_det =  flt_q[1] & ~flt[1] & flt[0] & flt_q[0];
  assign stop_det  = ~flt_q[1] &  flt[1] & flt[0] & flt_q[0];

  state_t      state;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic [1:0]  ptr;
  logic        rw, por_flag;
  logic [6:0]  ctl_a;
  logic [4:0]  ctl_b;
  logic [7:0]  status;

  assign status = {6'b0, por_flag, pilot_det};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; shreg <= '0; ptr <= '0; rw <= 1'b0;
      sda_oe <= 1'b0; por_flag <= 1'b1;
      vol_r <= '0; vol_l <= '0; ctl_a <= 7'h02; ctl_b <= '0;
    end else if (start_det) begin
      state <= S_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_SUB, S_WDAT: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], flt[1]};
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (state == S_ADDR) begin
              if (shreg[7:1] == {ADDR_HI, addr_strap}) begin
                rw <= shreg[0]; sda_oe <= 1'b1; state <= S_AACK;
              end else
                state <= S_IDLE;
            end else if (state == S_SUB) begin
              ptr <= shreg[1:0]; sda_oe <= 1'b1; state <= S_SACK;
            end else begin
              case (ptr)
                2'd0: vol_r <= shreg[6:0];
                2'd1: vol_l <= shreg[6:0];
                2'd2: ctl_a <= shreg[6:0];
                default: ctl_b <= shreg[4:0];
              endcase
              ptr <= ptr + 1'b1; sda_oe <= 1'b1; state <= S_DACK;
            end
          end
        end
        S_AACK: if (scl_fall) begin
          bitcnt <= '0;
          if (rw) begin
            shreg <= status; sda_oe <= ~status[7]; state <= S_RDAT;
          end else begin
            sda_oe <= 1'b0; state <= S_SUB;
          end
        end
        S_SACK, S_DACK: if (scl_fall) begin
          bitcnt <= '0; sda_oe <= 1'b0; state <= S_WDAT;
        end
        S_RDAT: if (scl_fall) begin
          if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0; por_flag <= 1'b0; state <= S_RACK;
          end else begin
            shreg  <= {shreg[6:0], 1'b0};
            sda_oe <= ~shreg[6];
            bitcnt <= bitcnt + 1'b1;
          end
        end
        S_RACK: if (scl_rise) state <= S_WAIT;
        default: ;
      endcase
    end
  end

  assign scl_oe         = 1'b0;
  assign line_stereo    = ctl_a[0];
  assign gen_mute       = ctl_a[1];
  assign avl_en         = ctl_a[2];
  assign avl_fast_decay = ctl_a[3];
  assign avl_attack     = ctl_a[5:4];
  assign line_mute      = ctl_a[6];
  assign tone_sel       = ctl_b[1:0];
  assign src_ext        = ctl_b[2];
  assign force_mono     = ctl_b[3];
  assign tone_linear    = ctl_b[4];

  assign mute_r = gen_mute | (vol_r <= MUTE_CODE);
  assign mute_l = gen_mute | (vol_l <= MUTE_CODE);

  assign gain_r_db = (vol_r <= MUTE_CODE) ? MUTE_DB :
                     (vol_r >= MAX_CODE)  ? MAX_DB  :
                     $signed({1'b0, vol_r}) - $signed({1'b0, UNITY_CODE});
  assign gain_l_db = (vol_l <= MUTE_CODE) ? MUTE_DB :
                     (vol_l >= MAX_CODE)  ? MAX_DB  :
                     $signed({1'b0, vol_l}) - $signed({1'b0, UNITY_CODE});

  assert_sda_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (state inside {S_AACK, S_SACK, S_DACK, S_RDAT}));

  assert_por_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_flag) |-> $past(state) == S_RDAT);

  assert_reg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({vol_r, vol_l, ctl_a, ctl_b}) |-> $past(state) == S_WDAT);

  assert_gmute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gen_mute |-> (mute_r && mute_l));

  assert_gain_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_r_db >= MUTE_DB) && (gain_r_db <= MAX_DB) &&
    (gain_l_db >= MUTE_DB) && (gain_l_db <= MAX_DB));

  assert_filter_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt[1]) |-> $past(s2[1]) != $past(flt[1]));

  assert_addr_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && $past(state) == S_ADDR && sda_oe) |-> 1'b0);
endmodule

// File: tb/audio_ctrl_i2c_slave_tb.sv
module audio_ctrl_i2c_slave_tb;
  localparam int Q = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_strap = 1'b1, pilot_det = 1'b0;
  logic scl_oe, sda_oe, sda_line;
  logic [6:0] vol_r, vol_l;
  logic signed [7:0] gain_r_db, gain_l_db;
  logic mute_r, mute_l, gen_mute, line_stereo, avl_en, avl_fast_decay, line_mute;
  logic src_ext, force_mono, tone_linear;
  logic [1:0] avl_attack, tone_sel;

  int checks = 0, errors = 0;
  logic [7:0] exp_reg [4];
  bit exp_por;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  audio_ctrl_i2c_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_strap(addr_strap), .pilot_det(pilot_det),
    .vol_r(vol_r), .vol_l(vol_l), .gain_r_db(gain_r_db), .gain_l_db(gain_l_db),
    .mute_r(mute_r), .mute_l(mute_l), .gen_mute(gen_mute), .line_stereo(line_stereo),
    .avl_en(avl_en), .avl_fast_decay(avl_fast_decay), .avl_attack(avl_attack),
    .line_mute(line_mute), .tone_sel(tone_sel), .src_ext(src_ext),
    .force_mono(force_mono), .tone_linear(tone_linear));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_gain(input int c);
    if (c <= 47) return -64;
    if (c >= 123) return 12;
    return c - 111;
  endfunction

  task automatic chk_all();
    int gm;
    gm = exp_reg[2][1];
    chk("R2 vol_r", vol_r, exp_reg[0][6:0]);
    chk("R2 vol_l", vol_l, exp_reg[1][6:0]);
    chk("R7 line_stereo", line_stereo, exp_reg[2][0]);
    chk("R7 gen_mute", gen_mute, gm);
    chk("R7 avl_en", avl_en, exp_reg[2][2]);
    chk("R7 avl_fast_decay", avl_fast_decay, exp_reg[2][3]);
    chk("R7 avl_attack", avl_attack, exp_reg[2][5:4]);
    chk("R7 line_mute", line_mute, exp_reg[2][6]);
    chk("R8 tone_sel", tone_sel, exp_reg[3][1:0]);
    chk("R8 src_ext", src_ext, exp_reg[3][2]);
    chk("R8 force_mono", force_mono, exp_reg[3][3]);
    chk("R8 tone_linear", tone_linear, exp_reg[3][4]);
    chk("R9 mute_r", mute_r, int'(gm != 0 || exp_reg[0][6:0] <= 7'h2F));
    chk("R9 mute_l", mute_l, int'(gm != 0 || exp_reg[1][6:0] <= 7'h2F));
    chk("R10 gain_r_db", int'(gain_r_db), exp_gain(int'(exp_reg[0][6:0])));
    chk("R10 gain_l_db", int'(gain_l_db), exp_gain(int'(exp_reg[1][6:0])));
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; m_scl = 1'b1; cycles(Q);
    m_sda = 1'b0; cycles(Q);
    m_scl = 1'b0; cycles(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; cycles(Q);
    m_scl = 1'b1; cycles(Q);
    m_sda = 1'b1; cycles(2 * Q);
  endtask

  task automatic send_bit(input bit b, input bit glitch);
    m_sda = b; cycles(Q);
    m_scl = 1'b1; cycles(Q);
    if (glitch) begin m_sda = ~b; cycles(3); m_sda = b; end
    cycles(Q);
    m_scl = 1'b0; cycles(Q);
  endtask

  task automatic recv_bit(output bit b);
    m_sda = 1'b1; cycles(Q);
    m_scl = 1'b1; cycles(Q);
    b = sda_line; cycles(Q);
    m_scl = 1'b0; cycles(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i], glitch);
    recv_bit(b);
    ack = ~b;
  endtask

  function automatic bit addr_ok(input logic [6:0] a);
    return a == {6'b101101, addr_strap};
  endfunction

  task automatic do_write(input logic [6:0] a, input logic [7:0] sub,
                          input int n, input logic [7:0] d [8], input bit glitch,
                          output bit ack0);
    bit ack;
    int p;
    i2c_start();
    send_byte({a, 1'b0}, 1'b0, ack0);
    send_byte(sub, 1'b0, ack);
    if (ack0) chk("R2 subaddress ack", ack, 1);
    p = sub[1:0];
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], glitch, ack);
      if (addr_ok(a)) begin
        chk("R2 data ack", ack, 1);
        exp_reg[p] = d[i];
        p = (p + 1) % 4;
      end else
        chk("R1 no ack on mismatch", ack, 0);
    end
    i2c_stop();
  endtask

  task automatic do_read(input logic [6:0] a, output bit ack0, output logic [7:0] s);
    bit b;
    s = '0;
    i2c_start();
    send_byte({a, 1'b1}, 1'b0, ack0);
    if (ack0) begin
      for (int i = 7; i >= 0; i--) begin recv_bit(b); s[i] = b; end
      send_bit(1'b1, 1'b0);
    end
    i2c_stop();
  endtask

  task automatic read_check(input logic [6:0] a);
    bit ack;
    logic [7:0] s;
    do_read(a, ack, s);
    chk("R1 read address ack", ack, int'(addr_ok(a)));
    if (ack) begin
      chk("R4 status byte", s, {6'b0, exp_por, pilot_det});
      exp_por = 1'b0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d [8];
    bit ack;
    logic [6:0] a;
    int k, n;
    void'($urandom(32'h5EED_1234));
    exp_reg[0] = 8'h00; exp_reg[1] = 8'h00; exp_reg[2] = 8'h02; exp_reg[3] = 8'h00;
    exp_por = 1'b1;
    cycles(10);
    rst_n = 1'b1;
    cycles(10);

    // R6 reset state
    chk("R6 sda released", sda_oe, 0);
    chk("R6 scl never driven", scl_oe, 0);
    chk("R6 gen_mute set", gen_mute, 1);
    chk_all();

    // R4 R5 status and flag clearing
    pilot_det = 1'b1;
    read_check(7'b1011011);
    chk("R5 flag cleared", int'(exp_por), 0);
    pilot_det = 1'b0;
    read_check(7'b1011011);

    // R2 R7 R8 R9 R10 directed write with full sequence
    d[0] = 8'h7B; d[1] = 8'h30; d[2] = 8'h3D; d[3] = 8'h1F;
    do_write(7'b1011011, 8'h00, 4, d, 1'b0, ack);
    chk("R1 address ack strap high", ack, 1);
    chk("R10 gain +12", int'(gain_r_db), 12);
    chk("R10 gain -63", int'(gain_l_db), -63);
    chk_all();

    // R3 wrap from 3 to 0, R2 upper subaddress and data bit 7 ignored
    d[0] = 8'h00; d[1] = 8'hFF; d[2] = 8'hAF; d[3] = 8'h6F;
    do_write(7'b1011011, 8'hFF, 4, d, 1'b0, ack);
    chk("R3 wrap to reg0", vol_r, 7'h7F);
    chk("R10 saturated gain", int'(gain_r_db), 12);
    chk("R9 mute code", mute_l, 1);
    chk("R10 mute code gain", int'(gain_l_db), -64);
    chk_all();

    // R1 mismatch leaves state unchanged
    d[0] = 8'h11; d[1] = 8'h22;
    do_write(7'b1011010, 8'h00, 2, d, 1'b0, ack);
    chk("R1 mismatch nack", ack, 0);
    chk_all();
    addr_strap = 1'b0;
    cycles(4);
    do_write(7'b1011011, 8'h01, 2, d, 1'b0, ack);
    chk("R1 old address nack strap low", ack, 0);
    do_write(7'b1011010, 8'h01, 2, d, 1'b0, ack);
    chk("R1 address ack strap low", ack, 1);
    chk_all();
    read_check(7'b1011010);

    // R11 glitches on SDA during SCL high within a data byte
    d[0] = 8'h5A; d[1] = 8'h25;
    do_write(7'b1011010, 8'h02, 2, d, 1'b1, ack);
    chk("R11 glitched ctl A", {1'b0, line_mute, avl_attack, avl_fast_decay, avl_en, gen_mute, line_stereo}, 8'h5A & 8'h7F);
    chk("R11 glitched ctl B", {3'b0, tone_linear, force_mono, src_ext, tone_sel}, 8'h25 & 8'h1F);
    chk_all();

    // random mix
    for (int t = 0; t < 24; t++) begin
      k = $urandom_range(0, 9);
      if (k == 9) begin
        addr_strap = ~addr_strap;
        cycles(4);
      end
      a = {6'b101101, addr_strap};
      if (k == 6) a = a ^ 7'(1 << $urandom_range(0, 6));
      if (k == 7 || k == 8) begin
        pilot_det = 1'($urandom_range(0, 1));
        read_check(a);
      end else begin
        n = $urandom_range(1, 6);
        for (int i = 0; i < 8; i++) d[i] = 8'($urandom);
        do_write(a, 8'($urandom), n, d, 1'b0, ack);
        chk("R1 random address ack", ack, int'(addr_ok(a)));
      end
      chk_all();
    end

    // R5 flag set again by reset
    rst_n = 1'b0;
    cycles(5);
    rst_n = 1'b1;
    cycles(10);
    exp_reg[0] = 8'h00; exp_reg[1] = 8'h00; exp_reg[2] = 8'h02; exp_reg[3] = 8'h00;
    exp_por = 1'b1;
    chk_all();
    read_check({6'b101101, addr_strap});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule